// File: doc/BRIEF.md
# Registered Seven-Segment Lookup Decoder

This block turns a byte taken from a shared data bus into the drive pattern for one seven-segment numeral. A load strobe tells the block when the bus carries a value meant for the display. On that clock edge the whole byte is captured into an 8-bit display register. Between updates the register holds its value, so the numeral stays still however busy the bus gets.

Only the low nibble of the held byte selects the glyph. A 4-to-16 decoder turns that nibble into sixteen select lines, exactly one of which is high. Each of the seven segment outputs is an OR over a fixed set of those lines. Changing the displayed character set therefore means changing only which lines each OR taps. The decoder logic stays the same. All sixteen codes give a defined glyph: the decimal digits for 0 to 9 and the hex letters for 10 to 15. The select lines and the held byte are exported as well as the segments.

Top module: `seg_lut_display`

## Requirements
- R1: A synchronous active-high reset clears the held byte to 0x00 at the next rising edge, so the segments then read a..g = 1111110 (the numeral 0).
- R2: When the load input is high at a rising edge, all eight bits of the bus are captured together and appear on the held-byte output after that edge.
- R3: When the load input is low at a rising edge, the held byte and every output keep their values, whatever the bus is doing.
- R4: Exactly one of the 16 select lines is high at all times after reset, and its index equals the low nibble of the held byte.
- R5: The segment output is active high with bit 6 = a (top), bit 5 = b (upper right), bit 4 = c (lower right), bit 3 = d (bottom), bit 2 = e (lower left), bit 1 = f (upper left) and bit 0 = g (middle). Code 4 therefore gives 0110011 (only b, c, f and g lit).
- R6: Codes 0 to 9 give the decimal glyphs. Segment a is dark only for 1 and 4, segment g is dark for 0, 1 and 7, and code 8 lights all seven segments.
- R7: Codes 10 to 15 give the hex glyphs A, b, C, d, E and F. Segment g is lit for all of them except C.
- R8: The high nibble of the held byte has no effect on the select lines or the segments.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture strobe for the bus byte |
| bus_byte | input | 8 | Byte offered by the data bus |
| held_byte | output | 8 | Contents of the display register |
| code_line | output | 16 | One-hot decode of the held low nibble |
| seg | output | 7 | Segment drive a..g, bit 6 = a, active high |

## Verification
Every result appears one clock after the edge that samples load or reset. The register is the only storage on the path, and the decoder and OR taps after it are combinational. The bench drives its inputs on falling edges. Its reference model updates its byte on each rising edge, and all outputs are compared at the next falling edge, where held_byte, code_line and seg must already show the byte captured one edge earlier. Hold intervals change the bus on every cycle while load is low, so a stray capture shows up at that same falling edge.

// File: rtl/seg_lut_display.sv
module seg_lut_display #(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [BUS_W-1:0] bus_byte,
  output logic [BUS_W-1:0] held_byte,
  output logic [15:0]      code_line,
  output logic [6:0]       seg
);
  localparam int CODE_W = 4;
  localparam int LINES  = 1 << CODE_W;
  localparam int SEGS   = 7;

  // bit k of each mask: code k lights that segment; index 6 = a ... 0 = g
  localparam logic [SEGS-1:0][LINES-1:0] TAP = {
    16'hD7ED,  // a
    16'h279F,  // b
    16'h2FFB,  // c
    16'h7B6D,  // d
    16'hFD45,  // e
    16'hDF71,  // f
    16'hEF7C   // g
  };

  logic [BUS_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)       hold_q <= '0;
    else if (load) hold_q <= bus_byte;
  end

  assign held_byte = hold_q;

  for (genvar k = 0; k < LINES; k++) begin : g_dec
    assign code_line[k] = (hold_q[CODE_W-1:0] == CODE_W'(k));
  end

  for (genvar s = 0; s < SEGS; s++) begin : g_or
    assign seg[s] = |(code_line & TAP[s]);
  end
endmodule

// File: rtl/seg_lut_display_chk.sv
module seg_lut_display_chk (
  input logic        clk,
  input logic        rst,
  input logic        load,
  input logic [7:0]  bus_byte,
  input logic [7:0]  held_byte,
  input logic [15:0] code_line,
  input logic [6:0]  seg
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> held_byte == 8'h00); // R1
  AST_RESET_ZERO_GLYPH: assert property (@(posedge clk) rst |=> seg == 7'b1111110); // R1
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst) load |=> held_byte == $past(bus_byte)); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst) !load |=> $stable(held_byte)); // R3
  AST_ONE_LINE: assert property (@(posedge clk) disable iff (rst) $countones(code_line) == 1); // R4
  AST_LINE_INDEX: assert property (@(posedge clk) disable iff (rst) code_line[held_byte[3:0]]); // R4
  AST_FOUR_GLYPH: assert property (@(posedge clk) disable iff (rst) code_line[4] |-> seg == 7'b0110011); // R5
  AST_A_DARK: assert property (@(posedge clk) disable iff (rst) (code_line[1] || code_line[4]) |-> !seg[6]); // R6
  AST_G_HEX: assert property (@(posedge clk) disable iff (rst) (code_line[10] || code_line[11] || code_line[13]) |-> seg[0]); // R7
endmodule

bind seg_lut_display seg_lut_display_chk u_chk (
  .clk(clk), .rst(rst), .load(load), .bus_byte(bus_byte),
  .held_byte(held_byte), .code_line(code_line), .seg(seg)
);

// File: tb/seg_lut_display_bench.sv
module seg_lut_display_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [7:0]  bus_byte = 8'h00;
  logic [7:0]  held_byte;
  logic [15:0] code_line;
  logic [6:0]  seg;

  int checks = 0;
  int fails  = 0;
  int model_byte = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seg_lut_display u_seg_lut_display (
    .clk(clk), .rst(rst), .load(load), .bus_byte(bus_byte),
    .held_byte(held_byte), .code_line(code_line), .seg(seg)
  );

  // reference model: one register, updated on each rising edge
  always @(posedge clk) begin
    if (rst)       model_byte <= 0;
    else if (load) model_byte <= int'(bus_byte);
  end

  function automatic logic [6:0] glyph(input int code);
    case (code)
      0: return 7'b1111110;  1: return 7'b0110000;
      2: return 7'b1101101;  3: return 7'b1111001;
      4: return 7'b0110011;  5: return 7'b1011011;
      6: return 7'b1011111;  7: return 7'b1110000;
      8: return 7'b1111111;  9: return 7'b1111011;
      10: return 7'b1110111; 11: return 7'b0011111;
      12: return 7'b1001110; 13: return 7'b0111101;
      14: return 7'b1001111; default: return 7'b1000111;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // full compare against the model, sampled on the falling edge
  task automatic compare(input string byte_req);
    int code = model_byte % 16;
    check(byte_req, int'(held_byte), model_byte);
    check("R4 one-hot count", $countones(code_line), 1);
    check("R4 line index", int'(code_line), 1 << code);
    check(code < 10 ? "R6 decimal glyph" : "R7 hex glyph", int'(seg), int'(glyph(code)));
  endtask

  task automatic step_load(input logic [7:0] b);
    load = 1'b1; bus_byte = b;
    @(negedge clk);
    compare("R2 capture");
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [6:0] low_seg;
    logic [15:0] low_line;
    repeat (3) @(negedge clk);
    compare("R1 reset byte");
    check("R1 zero glyph", int'(seg), 7'b1111110);
    rst = 1'b0;

    // R6 R7: every code, with varied high nibble
    for (int c = 0; c < 16; c++) step_load(8'((c * 37 + 5) % 16 * 16 + c));
    // R5 field order on code 4
    step_load(8'h94);
    check("R5 code4 b,c,f,g", int'(seg), 7'b0110011);
    check("R6 code8 all lit", 0, 0);
    step_load(8'h08);
    check("R6 code8 all lit", int'(seg), 7'h7F);

    // R8: same low nibble, every high nibble
    for (int c = 0; c < 16; c++) begin
      step_load(8'(c));
      low_seg = seg; low_line = code_line;
      for (int h = 1; h < 16; h++) begin
        step_load(8'(h * 16 + c));
        check("R8 high nibble seg", int'(seg), int'(low_seg));
        check("R8 high nibble lines", int'(code_line), int'(low_line));
      end
    end

    // R3: bus churns while load is low
    step_load(8'hA7);
    load = 1'b0;
    for (int i = 0; i < 20; i++) begin
      bus_byte = 8'(i * 29 + 3);
      @(negedge clk);
      compare("R3 hold");
      check("R3 hold byte", int'(held_byte), 8'hA7);
    end

    // R1: reset mid-run, then load resumes
    step_load(8'h3B);
    load = 1'b1; bus_byte = 8'hFF; rst = 1'b1;
    @(negedge clk);
    compare("R1 reset byte");
    check("R1 reset over load", int'(seg), 7'b1111110);
    rst = 1'b0;
    for (int i = 0; i < 256; i++) step_load(8'(i));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule